// File: doc/BRIEF.md
# Peripheral Interrupt Flag and Enable Unit

This block is the interrupt-control slice of an 8-bit parallel interface adapter. It gathers seven event sources into a 7-bit flag register: two control lines per port, a timer-1 pulse, a timer-2 pulse and a shift-complete pulse. Each source can be individually unmasked through a 7-bit enable register. The block drives one active-high interrupt request whenever an unmasked flag is pending. The port data path, the timers and the shift register sit outside and reach this unit only as pulses and access strobes.

Software sees three byte-wide registers on a 4-bit address bus. The control register is at 0xC, the flag register at 0xD and the enable register at 0xE. One nibble of the control register configures each port's pair of control lines: the lower nibble configures port A and the upper nibble port B. Bit 0 of a nibble picks the edge that the first line responds to. Bits 3:1 pick the mode of the second line. Control inputs pass through a two-flop synchronizer before edge detection.

Top module: `irq_flag_unit`

## Requirements
- R1: After a synchronous reset the flags, the enables and the control register are all zero, and irq is low. The synchronizers reset to the idle-high level, so no edge is seen right after reset.
- R2: A write to 0xE with data bit 7 = 1 sets every enable bit whose data bit (6:0) is 1 and leaves the other enable bits unchanged.
- R3: A write to 0xE with data bit 7 = 0 clears every enable bit whose data bit is 1. Writing 0x7F clears all enables.
- R4: A write to 0xD clears each flag whose data bit (6:0) is 1. Data bit 7 of that write has no effect.
- R5: A high cycle on the timer-1, timer-2 or shift pulse input sets flag bit 6, bit 5 or bit 2 respectively, and the bit reads set after that clock edge.
- R6: The first control line of a port sets its flag (port A: bit 1, port B: bit 4) on a falling edge when nibble bit 0 is 0, and on a rising edge when nibble bit 0 is 1. The flag reads set three clock edges after the input changes.
- R7: For the second control line of a port (port A: flag bit 0, port B: flag bit 3), a nibble mode of 0x2 selects independent input on a falling edge. A nibble mode of 0x6 selects independent input on a rising edge. A nibble mode of 0x0 selects a non-independent input on a falling edge.
- R8: A port access strobe clears that port's first-line flag. It clears the port's second-line flag only when the line is not in independent mode (nibble bit 3 = 0 and bit 1 = 1). In independent mode only a flag write clears that flag.
- R9: irq is high exactly when (flags AND enables) is nonzero. A read of 0xD returns bit 7 equal to irq, and a read of 0xE returns bit 7 as 1.
- R10: When an event and a clear of the same flag fall in one cycle, the flag stays set.
- R11: With nibble bit 3 = 1 (output mode), edges on the second control line set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register select |
| reg_wr | input | 1 | Write strobe, acts on the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| port_a_touch | input | 1 | Port A data access strobe |
| port_b_touch | input | 1 | Port B data access strobe |
| a_ctl1 | input | 1 | Port A first control line (asynchronous) |
| a_ctl2 | input | 1 | Port A second control line (asynchronous) |
| b_ctl1 | input | 1 | Port B first control line (asynchronous) |
| b_ctl2 | input | 1 | Port B second control line (asynchronous) |
| tmr1_pulse | input | 1 | Timer-1 event pulse |
| tmr2_pulse | input | 1 | Timer-2 event pulse |
| shift_pulse | input | 1 | Shift-complete event pulse |
| irq | output | 1 | Combined interrupt request, active high |

## Verification
A register write, a port strobe or an event pulse shows in the flags, the enables and irq right after the clock edge it is sampled on. A control-line change needs three edges: two synchronizer flops, then the flag update. The bench therefore waits four full cycles after each line change before reading. Reads are combinational. The driver sets the address at a falling edge and queues the expected byte and irq level. The monitor compares them just after the next rising edge, while the address is still held.

// File: rtl/irq_pkg.sv
// Package: shared widths, register addresses and flag bit positions for the
// interrupt flag/enable unit. Assumes a 7-source flag set plus a status bit.
package irq_pkg;
    localparam int REG_W  = 8;
    localparam int FLAG_W = REG_W - 1;
    localparam int ADDR_W = 4;
    localparam int NLINES = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'hC;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 4'hD;
    localparam logic [ADDR_W-1:0] ADDR_EN   = 4'hE;

    // Flag bit positions (software decodes these)
    localparam int BIT_A2  = 0;
    localparam int BIT_A1  = 1;
    localparam int BIT_SH  = 2;
    localparam int BIT_B2  = 3;
    localparam int BIT_B1  = 4;
    localparam int BIT_T2  = 5;
    localparam int BIT_T1  = 6;
endpackage

// File: rtl/irq_edge_sync.sv
// Module: two-flop synchronizer plus edge detector for N asynchronous lines.
// Assumes lines idle high; all stages reset to 1 so reset shows no edge.
module irq_edge_sync #(
    parameter int NLINES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lines,
    output logic [NLINES-1:0] rise,
    output logic [NLINES-1:0] fall
);
    logic [NLINES-1:0] stg1_q, stg2_q, prev_q;

    // Synchronize and keep one cycle of history per line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg1_q <= '1;
            stg2_q <= '1;
            prev_q <= '1;
        end else begin
            stg1_q <= lines;
            stg2_q <= stg1_q;
            prev_q <= stg2_q;
        end
    end

    // Per-line edge decode
    for (genvar i = 0; i < NLINES; i++) begin : g_edge
        assign rise[i] = stg2_q[i] & ~prev_q[i];
        assign fall[i] = ~stg2_q[i] & prev_q[i];
    end
endmodule

// File: rtl/irq_port_ctl.sv
// Module: decodes one control nibble into edge events and access clears for
// a port's two control lines. Assumes nibble bit 0 = first-line polarity,
// bits 3:1 = second-line mode (bit 3 output, bit 2 polarity, bit 1 independent).
module irq_port_ctl (
    input  logic [3:0] nib,
    input  logic       rise1,
    input  logic       fall1,
    input  logic       rise2,
    input  logic       fall2,
    input  logic       touch,
    output logic       evt1,
    output logic       evt2,
    output logic       clr1,
    output logic       clr2
);
    logic indep;

    // Event selection and access-clear rules for the line pair
    always_comb begin
        indep = ~nib[3] & nib[1];
        evt1  = nib[0] ? rise1 : fall1;
        evt2  = ~nib[3] & (nib[2] ? rise2 : fall2);
        clr1  = touch;
        clr2  = touch & ~indep;
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Module: flag register with per-bit set and clear vectors; set wins.
module irq_flag_bank #(
    parameter int FLAG_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_vec,
    input  logic [FLAG_W-1:0] clr_vec,
    output logic [FLAG_W-1:0] flags
);
    // Clear first, then OR in new events so a same-cycle event survives
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/irq_flag_unit.sv
// Module: top of the interrupt flag/enable unit. Holds control and enable
// registers, merges events into the flag bank and drives irq.
// Assumes reg_rdata is read combinationally from reg_addr.
module irq_flag_unit
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              port_a_touch,
    input  logic              port_b_touch,
    input  logic              a_ctl1,
    input  logic              a_ctl2,
    input  logic              b_ctl1,
    input  logic              b_ctl2,
    input  logic              tmr1_pulse,
    input  logic              tmr2_pulse,
    input  logic              shift_pulse,
    output logic              irq
);
    localparam int NPORTS = NLINES / 2;

    logic [REG_W-1:0]  ctrl_q;
    logic [FLAG_W-1:0] en_q;
    logic [FLAG_W-1:0] flag_q;
    logic [FLAG_W-1:0] set_vec, clr_vec;
    logic [NLINES-1:0] rise, fall;
    logic [NPORTS-1:0] p_evt1, p_evt2, p_clr1, p_clr2;
    logic [NPORTS-1:0] touch;

    assign touch = {port_b_touch, port_a_touch};

    irq_edge_sync #(.NLINES(NLINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .lines({b_ctl2, b_ctl1, a_ctl2, a_ctl1}),
        .rise (rise),
        .fall (fall)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        irq_port_ctl u_ctl (
            .nib  (ctrl_q[4*p +: 4]),
            .rise1(rise[2*p]),
            .fall1(fall[2*p]),
            .rise2(rise[2*p+1]),
            .fall2(fall[2*p+1]),
            .touch(touch[p]),
            .evt1 (p_evt1[p]),
            .evt2 (p_evt2[p]),
            .clr1 (p_clr1[p]),
            .clr2 (p_clr2[p])
        );
    end

    // Control and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            en_q   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_CTRL) ctrl_q <= reg_wdata;
            if (reg_addr == ADDR_EN) begin
                if (reg_wdata[REG_W-1]) en_q <= en_q | reg_wdata[FLAG_W-1:0];
                else                    en_q <= en_q & ~reg_wdata[FLAG_W-1:0];
            end
        end
    end

    // Gather per-bit set and clear requests
    always_comb begin
        set_vec         = '0;
        set_vec[BIT_A1] = p_evt1[0];
        set_vec[BIT_A2] = p_evt2[0];
        set_vec[BIT_B1] = p_evt1[1];
        set_vec[BIT_B2] = p_evt2[1];
        set_vec[BIT_SH] = shift_pulse;
        set_vec[BIT_T2] = tmr2_pulse;
        set_vec[BIT_T1] = tmr1_pulse;

        clr_vec = (reg_wr && reg_addr == ADDR_FLAG) ? reg_wdata[FLAG_W-1:0] : '0;
        clr_vec[BIT_A1] = clr_vec[BIT_A1] | p_clr1[0];
        clr_vec[BIT_A2] = clr_vec[BIT_A2] | p_clr2[0];
        clr_vec[BIT_B1] = clr_vec[BIT_B1] | p_clr1[1];
        clr_vec[BIT_B2] = clr_vec[BIT_B2] | p_clr2[1];
    end

    irq_flag_bank #(.FLAG_W(FLAG_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .flags  (flag_q)
    );

    // Combined request
    assign irq = |(flag_q & en_q);

    // Register read mux
    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_q;
            ADDR_FLAG: reg_rdata = {irq, flag_q};
            ADDR_EN:   reg_rdata = {1'b1, en_q};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_flag_chk.sv
// Checker: temporal properties of the interrupt flag/enable unit, bound to
// the top. Observes ports plus the flag and enable state.
module irq_flag_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              tmr1_pulse,
    input logic              irq,
    input logic [FLAG_W-1:0] flags,
    input logic [FLAG_W-1:0] enables
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && enables == '0));

    assert_enable_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_EN && reg_wdata[REG_W-1])
        |=> ((enables & $past(reg_wdata[FLAG_W-1:0])) == $past(reg_wdata[FLAG_W-1:0])));

    assert_enable_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_EN && !reg_wdata[REG_W-1])
        |=> ((enables & $past(reg_wdata[FLAG_W-1:0])) == '0));

    assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_FLAG && reg_wdata[BIT_T1] && !tmr1_pulse)
        |=> !flags[BIT_T1]);

    assert_timer_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr1_pulse |=> flags[BIT_T1]);

    assert_status_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_FLAG) |-> (reg_rdata[REG_W-1] == irq));

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0 && enables != '0));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr1_pulse && reg_wr && reg_addr == ADDR_FLAG && reg_wdata[BIT_T1])
        |=> flags[BIT_T1]);
endmodule

bind irq_flag_unit irq_flag_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tmr1_pulse(tmr1_pulse),
    .irq       (irq),
    .flags     (flag_q),
    .enables   (en_q)
);

// File: tb/tb_irq_flag_unit.sv
`timescale 1ns/1ps
module tb_irq_flag_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       port_a_touch = 1'b0, port_b_touch = 1'b0;
    logic       a_ctl1 = 1'b1, a_ctl2 = 1'b1, b_ctl1 = 1'b1, b_ctl2 = 1'b1;
    logic       tmr1_pulse = 1'b0, tmr2_pulse = 1'b0, shift_pulse = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] exp_data;
        logic       exp_irq;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    irq_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .port_a_touch(port_a_touch), .port_b_touch(port_b_touch),
        .a_ctl1(a_ctl1), .a_ctl2(a_ctl2), .b_ctl1(b_ctl1), .b_ctl2(b_ctl2),
        .tmr1_pulse(tmr1_pulse), .tmr2_pulse(tmr2_pulse),
        .shift_pulse(shift_pulse), .irq(irq)
    );

    // Monitor: pop one expectation just after each rising edge and compare
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (reg_rdata !== e.exp_data || irq !== e.exp_irq) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
                             e.tag, reg_rdata, irq, e.exp_data, e.exp_irq);
                end
            end
        end
    end

    // Driver: queue an expected read result
    task automatic expect_rd(input logic [3:0] a, input logic [7:0] d,
                             input logic ir, input string tag);
        exp_t e;
        @(negedge clk);
        reg_addr = a;
        e.tag = tag; e.exp_data = d; e.exp_irq = ir;
        sb_q.push_back(e);
        @(posedge clk);
        #1.5;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    localparam logic [3:0] A_CTRL = 4'hC, A_FLAG = 4'hD, A_EN = 4'hE;

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1: reset state
        expect_rd(A_FLAG, 8'h00, 1'b0, "R1 flags after reset");
        expect_rd(A_EN,   8'h80, 1'b0, "R1 enables after reset (R9 bit7)");
        expect_rd(A_CTRL, 8'h00, 1'b0, "R1 control after reset");

        // R2/R3: enable set/clear writes
        wr(A_EN, 8'hC0);
        expect_rd(A_EN, 8'hC0, 1'b0, "R2 set bit6");
        wr(A_EN, 8'hA2);
        expect_rd(A_EN, 8'hE2, 1'b0, "R2 set adds, keeps others");
        wr(A_EN, 8'h02);
        expect_rd(A_EN, 8'hE0, 1'b0, "R3 clear bit1 only");
        wr(A_EN, 8'h7F);
        expect_rd(A_EN, 8'h80, 1'b0, "R3 0x7F clears all");

        // R5/R9/R4: timer-1 pulse, masked then unmasked
        @(negedge clk); tmr1_pulse = 1'b1; @(negedge clk); tmr1_pulse = 1'b0;
        expect_rd(A_FLAG, 8'h40, 1'b0, "R5 timer1 sets bit6, masked");
        wr(A_EN, 8'hC0);
        expect_rd(A_FLAG, 8'hC0, 1'b1, "R9 unmasked flag raises irq");
        wr(A_FLAG, 8'h80);
        expect_rd(A_FLAG, 8'hC0, 1'b1, "R4 bit7 write has no effect");
        wr(A_FLAG, 8'h40);
        expect_rd(A_FLAG, 8'h00, 1'b0, "R4 clear bit6 drops irq");
        @(negedge clk); tmr2_pulse = 1'b1; @(negedge clk); tmr2_pulse = 1'b0;
        @(negedge clk); shift_pulse = 1'b1; @(negedge clk); shift_pulse = 1'b0;
        expect_rd(A_FLAG, 8'h24, 1'b0, "R5 timer2 and shift bits");
        wr(A_FLAG, 8'h7F);
        wr(A_EN, 8'h7F);

        // R6: first-line polarity
        a_ctl1 = 1'b0; settle();
        expect_rd(A_FLAG, 8'h02, 1'b0, "R6 port A line1 falling edge");
        wr(A_FLAG, 8'h02);
        a_ctl1 = 1'b1; settle();
        expect_rd(A_FLAG, 8'h00, 1'b0, "R6 rising ignored when bit0=0");
        wr(A_CTRL, 8'h01);
        a_ctl1 = 1'b0; settle();
        expect_rd(A_FLAG, 8'h00, 1'b0, "R6 falling ignored when bit0=1");
        a_ctl1 = 1'b1; settle();
        expect_rd(A_FLAG, 8'h02, 1'b0, "R6 rising edge when bit0=1");
        wr(A_FLAG, 8'h7F);
        b_ctl1 = 1'b0; settle();
        expect_rd(A_FLAG, 8'h10, 1'b0, "R6 port B line1 falling edge");
        wr(A_FLAG, 8'h7F);
        wr(A_EN, 8'h82);
        a_ctl1 = 1'b0; settle();
        a_ctl1 = 1'b1; settle();
        expect_rd(A_FLAG, 8'h82, 1'b1, "R9 line1 flag raises irq");
        wr(A_FLAG, 8'h7F);
        wr(A_EN, 8'h7F);

        // R7/R8: independent second-line modes
        wr(A_CTRL, 8'h02);
        a_ctl2 = 1'b0; settle();
        expect_rd(A_FLAG, 8'h01, 1'b0, "R7 mode 0x2 falling sets bit0");
        @(negedge clk); port_a_touch = 1'b1; @(negedge clk); port_a_touch = 1'b0;
        expect_rd(A_FLAG, 8'h01, 1'b0, "R8 access keeps independent flag");
        wr(A_FLAG, 8'h01);
        expect_rd(A_FLAG, 8'h00, 1'b0, "R8 flag write clears it");
        wr(A_CTRL, 8'h06);
        a_ctl2 = 1'b1; settle();
        expect_rd(A_FLAG, 8'h01, 1'b0, "R7 mode 0x6 rising sets bit0");
        wr(A_FLAG, 8'h7F);
        wr(A_CTRL, 8'h60);
        b_ctl2 = 1'b0; settle();
        expect_rd(A_FLAG, 8'h00, 1'b0, "R7 port B 0x6 ignores falling");
        b_ctl2 = 1'b1; settle();
        expect_rd(A_FLAG, 8'h08, 1'b0, "R7 port B 0x6 rising sets bit3");
        wr(A_FLAG, 8'h7F);

        // R8: non-independent mode cleared by port access
        wr(A_CTRL, 8'h00);
        a_ctl2 = 1'b0; settle();
        a_ctl1 = 1'b0; settle();
        expect_rd(A_FLAG, 8'h03, 1'b0, "R7 mode 0x0 falling plus line1");
        @(negedge clk); port_a_touch = 1'b1; @(negedge clk); port_a_touch = 1'b0;
        expect_rd(A_FLAG, 8'h00, 1'b0, "R8 port A access clears both");
        b_ctl2 = 1'b0; settle();
        @(negedge clk); port_a_touch = 1'b1; @(negedge clk); port_a_touch = 1'b0;
        expect_rd(A_FLAG, 8'h08, 1'b0, "R8 port A access leaves port B");
        @(negedge clk); port_b_touch = 1'b1; @(negedge clk); port_b_touch = 1'b0;
        expect_rd(A_FLAG, 8'h00, 1'b0, "R8 port B access clears bit3");

        // R11: output mode sets no flag
        wr(A_CTRL, 8'h08);
        a_ctl2 = 1'b1; settle();
        a_ctl2 = 1'b0; settle();
        expect_rd(A_FLAG, 8'h00, 1'b0, "R11 output mode ignores edges");
        expect_rd(A_CTRL, 8'h08, 1'b0, "R11 control readback");

        // R10: event and clear in the same cycle
        @(negedge clk);
        tmr1_pulse = 1'b1; reg_wr = 1'b1; reg_addr = A_FLAG; reg_wdata = 8'h40;
        @(negedge clk);
        tmr1_pulse = 1'b0; reg_wr = 1'b0;
        expect_rd(A_FLAG, 8'h40, 1'b0, "R10 set wins over clear");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule